// File: doc/BRIEF.md
# ALU Status Flag Generator

This block forms the 9-bit raw result of an 8-bit add, subtract, AND or pass operation and folds the resulting condition flags into a processor status register. The caller presents two operands, an operation code and an update-group code. The group code picks which flags the operation may write. Every status bit outside that group keeps its value.

The register holds five live bits. Carry sits at bit 0, digit carry at bit 1 and zero at bit 2. Bits 3 and 4 depend on a mode input. In classic mode they are the power-down and time-out bits, and arithmetic never writes them. In extended mode the same two bits carry overflow (bit 3) and negative (bit 4). In either mode a separate strobe per bit can write bit 3 or bit 4 on its own. On subtraction, carry and digit carry read as "no borrow".

Top module: `alu_status_unit`

## Requirements
- R1: A synchronous reset, active high, loads the status register with 0x18: bits 3 and 4 set, all other bits clear.
- R2: `result` is combinational. For op_sel 0 it is op_a+op_b in 9 bits. For op_sel 1 it is op_a-op_b modulo 512, so bit 8 is set when a borrow occurs. For op_sel 2 it is op_a AND op_b, and for op_sel 3 it is op_b. For codes 2 and 3, bit 8 is 0.
- R3: When written, Z (bit 2) is 1 exactly when result[7:0] is zero.
- R4: When written, C (bit 0) equals result[8], except for op_sel 1, where it equals the inverse of result[8].
- R5: When written, DC (bit 1) equals bit 4 of (result XOR op_a XOR op_b), except for op_sel 1, where it equals the inverse of that bit.
- R6: In extended mode (ext_mode=1), N (bit 4) copies result[7]. OV (bit 3) is set as follows. For op_sel 1 it is bit 7 of (op_a & ~op_b & ~result) | (result & ~op_a & op_b). For the other codes it is set when op_a[7]==op_b[7] and result[7] differs from them.
- R7: The upd_grp codes select flags as follows: 1 = Z, 2 = C, 3 = N+Z, 4 = Z+C+N, 5 = Z+C+DC, 6 = Z+C+DC+OV+N. Codes 0 and 7 select nothing. Unselected bits keep their value.
- R8: In classic mode (ext_mode=0), no group writes bits 3 and 4.
- R9: pd_we writes pd_in into bit 3, and to_we writes to_in into bit 4. Each strobe touches only its own bit and wins over a flag update to that bit in the same cycle.
- R10: The status register changes only on a rising clock edge, and `status[7:5]` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_mode | input | 1 | 1: bits 3/4 are OV/N; 0: bits 3/4 are PD/TO |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| op_sel | input | 2 | 0 add, 1 subtract, 2 AND, 3 pass op_b |
| upd_grp | input | 3 | Flag update group code |
| pd_we | input | 1 | Write strobe for bit 3 |
| pd_in | input | 1 | Value written to bit 3 |
| to_we | input | 1 | Write strobe for bit 4 |
| to_in | input | 1 | Value written to bit 4 |
| result | output | 9 | Raw 9-bit result |
| status | output | 8 | Status register contents |

## Verification
Additions are exercised with four patterns:
- A nibble-crossing sum (0x0F+0x01) separates digit carry from carry.
- 0x80+0x80 produces carry, zero and overflow together.
- 0x7F+0x01 produces overflow with a negative result and no carry.
- 0x00+0x00 sets zero with no carry.

Subtractions are exercised with four patterns:
- 5-3 gives no borrow at all.
- 3-5 gives a full borrow.
- 0x10-0x01 borrows only out of the low nibble.
- 0x80-0x01 gives signed overflow.

Together these show that carry and digit carry are inverted on subtraction. Each group code, in both modes and together with the bit-3 and bit-4 strobes, is applied on top of a known status value, so a bit written wrongly or left untouched shows up.

// File: rtl/alu_status_unit.sv
module alu_status_unit (
  input  logic       clk,
  input  logic       rst,
  input  logic       ext_mode,
  input  logic [7:0] op_a,
  input  logic [7:0] op_b,
  input  logic [1:0] op_sel,
  input  logic [2:0] upd_grp,
  input  logic       pd_we,
  input  logic       pd_in,
  input  logic       to_we,
  input  logic       to_in,
  output logic [8:0] result,
  output logic [7:0] status
);
  localparam int BC  = 0;
  localparam int BDC = 1;
  localparam int BZ  = 2;
  localparam int B3  = 3;
  localparam int B4  = 4;
  localparam logic [4:0] RST_VAL = 5'b11000;

  logic [4:0] st, nxt, msk, flg;
  logic [8:0] sum, dif;
  logic       is_sub, hx, f_ov;

  assign sum    = {1'b0, op_a} + {1'b0, op_b};
  assign dif    = {1'b0, op_a} - {1'b0, op_b};
  assign is_sub = (op_sel == 2'd1);

  always_comb begin
    case (op_sel)
      2'd0:    result = sum;
      2'd1:    result = dif;
      2'd2:    result = {1'b0, op_a & op_b};
      default: result = {1'b0, op_b};
    endcase
  end

  assign hx   = result[4] ^ op_a[4] ^ op_b[4];
  assign f_ov = is_sub ? ((op_a[7] & ~op_b[7] & ~result[7]) | (result[7] & ~op_a[7] & op_b[7]))
                       : ((op_a[7] == op_b[7]) && (result[7] != op_a[7]));

  assign flg[BC]  = is_sub ? ~result[8] : result[8];
  assign flg[BDC] = is_sub ? ~hx : hx;
  assign flg[BZ]  = (result[7:0] == 8'd0);
  assign flg[B3]  = f_ov;
  assign flg[B4]  = result[7];

  always_comb begin
    case (upd_grp)
      3'd1:    msk = 5'b00100;
      3'd2:    msk = 5'b00001;
      3'd3:    msk = 5'b10100;
      3'd4:    msk = 5'b10101;
      3'd5:    msk = 5'b00111;
      3'd6:    msk = 5'b11111;
      default: msk = 5'b00000;
    endcase
    if (!ext_mode) msk[B4:B3] = 2'b00;
    nxt = (st & ~msk) | (flg & msk);
    if (pd_we) nxt[B3] = pd_in;
    if (to_we) nxt[B4] = to_in;
  end

  always_ff @(posedge clk) begin
    if (rst) st <= RST_VAL;
    else     st <= nxt;
  end

  assign status = {3'b000, st};

  // R1
  reset_value_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (st == RST_VAL));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((upd_grp == 3'd0 || upd_grp == 3'd7) && !pd_we && !to_we) |=> $stable(status));

  // R3
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_grp == 3'd1 || upd_grp == 3'd6) |=> (status[BZ] == ($past(result[7:0]) == 8'd0)));

  // R4
  sub_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (is_sub && upd_grp == 3'd2) |=> (status[BC] == !$past(result[8])));

  // R8
  classic_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!ext_mode && !pd_we && !to_we) |=> $stable(status[B4:B3]));

  // R9
  pd_write_chk: assert property (@(posedge clk) disable iff (rst)
    pd_we |=> (status[B3] == $past(pd_in)));

  // R10
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    status[7:5] == 3'b000);
endmodule

// File: tb/tb_alu_status_unit.sv
module tb_alu_status_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_mode = 1'b1;
  logic [7:0] op_a = '0, op_b = '0;
  logic [1:0] op_sel = '0;
  logic [2:0] upd_grp = '0;
  logic       pd_we = 1'b0, pd_in = 1'b0, to_we = 1'b0, to_in = 1'b0;
  logic [8:0] result;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_st;

  always #2 clk = ~clk;

  alu_status_unit dut (
    .clk(clk), .rst(rst), .ext_mode(ext_mode), .op_a(op_a), .op_b(op_b),
    .op_sel(op_sel), .upd_grp(upd_grp), .pd_we(pd_we), .pd_in(pd_in),
    .to_we(to_we), .to_in(to_in), .result(result), .status(status)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] ref_res(input logic [7:0] a, b, input logic [1:0] s);
    case (s)
      2'd0:    return {1'b0, a} + {1'b0, b};
      2'd1:    return ({1'b0, a} - {1'b0, b}) & 9'h1FF;
      2'd2:    return {1'b0, a & b};
      default: return {1'b0, b};
    endcase
  endfunction

  function automatic logic [7:0] ref_st(input logic [7:0] s, input logic e,
      input logic [7:0] a, b, input logic [1:0] op, input logic [2:0] g,
      input logic pw, pv, tw, tv);
    logic [8:0] r;
    logic z, c, dc, ov, n, sb, h;
    logic [7:0] o;
    r  = ref_res(a, b, op);
    sb = (op == 2'd1);
    z  = (r[7:0] == 0);
    c  = sb ? !r[8] : r[8];
    h  = r[4] ^ a[4] ^ b[4];
    dc = sb ? !h : h;
    n  = r[7];
    if (sb) ov = (a[7] && !b[7] && !r[7]) || (r[7] && !a[7] && b[7]);
    else    ov = (a[7] == b[7]) && (r[7] != a[7]);
    o = s;
    if (g == 1 || g == 3 || g == 4 || g == 5 || g == 6) o[2] = z;
    if (g == 2 || g == 4 || g == 5 || g == 6) o[0] = c;
    if (g == 5 || g == 6) o[1] = dc;
    if (e && g == 6) o[3] = ov;
    if (e && (g == 3 || g == 4 || g == 6)) o[4] = n;
    if (pw) o[3] = pv;
    if (tw) o[4] = tv;
    return o;
  endfunction

  task automatic step(input string tag, input logic e, input logic [7:0] a, b,
      input logic [1:0] op, input logic [2:0] g,
      input logic pw = 0, input logic pv = 0, input logic tw = 0, input logic tv = 0);
    @(negedge clk);
    ext_mode = e; op_a = a; op_b = b; op_sel = op; upd_grp = g;
    pd_we = pw; pd_in = pv; to_we = tw; to_in = tv;
    #1;
    chk({tag, " R2 result"}, result, ref_res(a, b, op));
    exp_st = ref_st(exp_st, e, a, b, op, g, pw, pv, tw, tv);
    @(posedge clk); #1;
    upd_grp = 3'd0; pd_we = 0; to_we = 0;
    chk({tag, " status"}, status, exp_st);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    exp_st = 8'h18;
    chk("R1 reset value", status, 8'h18);
    chk("R10 upper bits zero", status[7:5], 0);
  endtask

  task automatic t_add();
    step("R5 add nibble carry", 1, 8'h0F, 8'h01, 2'd0, 3'd6);
    chk("R5 DC set", status[1], 1);
    step("R6 add overflow carry", 1, 8'h80, 8'h80, 2'd0, 3'd6);
    chk("R4 C set", status[0], 1);
    chk("R3 Z set", status[2], 1);
    step("R6 add overflow negative", 1, 8'h7F, 8'h01, 2'd0, 3'd6);
    chk("R6 OV N", status[4:3], 2'b11);
    step("R3 add zero", 1, 8'h00, 8'h00, 2'd0, 3'd6);
  endtask

  task automatic t_sub();
    step("R4 sub no borrow", 1, 8'h05, 8'h03, 2'd1, 3'd6);
    chk("R4 C not-borrow", status[0], 1);
    step("R4 sub borrow", 1, 8'h03, 8'h05, 2'd1, 3'd6);
    chk("R4 C borrow", status[0], 0);
    step("R5 sub nibble borrow", 1, 8'h10, 8'h01, 2'd1, 3'd6);
    chk("R5 DC borrow", status[1], 0);
    step("R6 sub overflow", 1, 8'h80, 8'h01, 2'd1, 3'd6);
    chk("R6 sub OV", status[3], 1);
  endtask

  task automatic t_groups();
    step("R7 and N+Z", 1, 8'hF0, 8'h0F, 2'd2, 3'd3);
    step("R7 pass N+Z", 1, 8'h00, 8'h9A, 2'd3, 3'd3);
    step("R7 Z only", 1, 8'h01, 8'hFF, 2'd0, 3'd1);
    step("R7 C only", 1, 8'hFF, 8'h01, 2'd0, 3'd2);
    step("R7 Z+C+N", 1, 8'h40, 8'h40, 2'd0, 3'd4);
    step("R7 Z+C+DC", 1, 8'h08, 8'h08, 2'd0, 3'd5);
    step("R7 group 0 keeps", 1, 8'h80, 8'h80, 2'd0, 3'd0);
    step("R7 group 7 keeps", 1, 8'h00, 8'h00, 2'd1, 3'd7);
  endtask

  task automatic t_classic();
    step("R9 set bits 3,4", 0, 8'h00, 8'h00, 2'd0, 3'd0, 1, 1, 1, 1);
    step("R8 classic all-group add", 0, 8'h80, 8'h00, 2'd0, 3'd6);
    chk("R8 bits 3,4 kept", status[4:3], 2'b11);
    step("R8 classic N+Z", 0, 8'h00, 8'h00, 2'd1, 3'd3);
  endtask

  task automatic t_pdto();
    step("R9 pd clear only", 0, 8'h00, 8'h00, 2'd0, 3'd0, 1, 0, 0, 0);
    chk("R9 pd bit", status[4:3], 2'b10);
    step("R9 to clear only", 0, 8'h00, 8'h00, 2'd0, 3'd0, 0, 0, 1, 0);
    step("R9 strobe beats flags", 1, 8'h7F, 8'h01, 2'd0, 3'd6, 1, 0, 1, 1);
    chk("R9 bits 3,4", status[4:3], 2'b10);
    chk("R10 upper bits zero", status[7:5], 0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    exp_st = 8'h18;
    t_reset();
    t_add();
    t_sub();
    t_groups();
    t_classic();
    t_pdto();
    t_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule